// File: doc/BRIEF.md
# Read-Sequence Command Detector for a Nonvolatile-Backed SRAM

This block listens to the asynchronous bus of a static memory that has a nonvolatile shadow copy. It raises a save-to-nonvolatile command (STORE) or a restore-from-nonvolatile command (RECALL) when it sees a fixed series of six read accesses. There is no command register. Each access counts as a step at the moment chip enable goes low. The block runs on a synchronous system clock, and chip enable and write enable pass through synchronizers before use. The address is taken at the synchronized chip-enable falling edge. The bench holds it stable while chip enable is low.

The first five addresses are the same for both commands. Only the sixth address chooses between STORE and RECALL. When a full, correctly ordered series completes, the block pulses `store_req` or `recall_req` for one clock. It then holds `bus_inhibit` high while the operation runs, and the memory core uses this signal to cut off its data path. A STORE runs as an erase phase followed by a program phase, and each phase is shown on its own output. A RECALL runs for a single interval whose length is set by a parameter. The detector never alters read data: the reads that form a command still return array contents.

Top module: `nvseq_detect`

## Requirements
- R1: After a synchronous reset, `store_req`, `recall_req`, `bus_inhibit`, `erase_active` and `program_active` are all 0.
- R2: Six reads at PREFIX[0..4] followed by STORE_LAST, with no other access between them, give exactly one `store_req` pulse that lasts one clock.
- R3: The same five prefix reads followed by RECALL_LAST give exactly one `recall_req` pulse that lasts one clock, and no `store_req`.
- R4: A read whose address is not the expected next entry clears the progress. If that address equals PREFIX[0], it counts as step one of a new series.
- R5: A write cycle (chip enable low with write enable low) abandons any partial series.
- R6: Each chip-enable falling edge counts as exactly one step, however long chip enable stays low. Repeating an address in a second access is a mismatch.
- R7: After a STORE request, `bus_inhibit` rises in the next clock and stays high for exactly STORE_CYCLES clocks.
- R8: During a STORE, `erase_active` is high for the first ERASE_CYCLES busy clocks. `program_active` is high for the remaining STORE_CYCLES-ERASE_CYCLES clocks. The two are never high together, and program always directly follows erase.
- R9: After a RECALL request, `bus_inhibit` is high for exactly RECALL_CYCLES clocks, and neither phase output rises.
- R10: Accesses made while `bus_inhibit` is high are ignored. A complete series issued during an operation produces no request, then or later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Bus chip enable, active low, asynchronous |
| we_n | input | 1 | Bus write enable, active low, asynchronous |
| addr | input | ADDR_W | Bus address, held stable while chip enable is low |
| store_req | output | 1 | One-clock STORE command pulse |
| recall_req | output | 1 | One-clock RECALL command pulse |
| bus_inhibit | output | 1 | High while an operation is running |
| erase_active | output | 1 | STORE erase phase in progress |
| program_active | output | 1 | STORE program phase in progress |

## Verification
The assertions rely on three conditions. Chip enable stays low for at least two clocks, the address is stable for the whole low period, and every bus edge is far enough apart from the next for the synchronizers to settle. The bench drives every access through one task. That task changes the address and the enables only on falling clock edges, holds chip enable low for several clocks, and leaves several idle clocks between accesses. All parameters are left at their defaults, so each STORE runs for longer than a complete six-read series takes, which lets the series in the R10 test fall inside the busy window.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;
  localparam int SEQ_LEN    = 6;
  localparam int PREFIX_LEN = SEQ_LEN - 1;

  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_STORE  = 2'd1,
    OP_RECALL = 2'd2
  } nv_op_e;
endpackage

// File: rtl/nvseq_sync.sv
module nvseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ce_n_raw,
  input  logic we_n_raw,
  output logic ce_low,
  output logic we_low,
  output logic ce_fall
);
  logic [STAGES-1:0] ce_pipe;
  logic [STAGES-1:0] we_pipe;
  logic              ce_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_pipe <= '1;
      we_pipe <= '1;
      ce_last <= 1'b1;
    end else begin
      ce_pipe <= {ce_pipe[STAGES-2:0], ce_n_raw};
      we_pipe <= {we_pipe[STAGES-2:0], we_n_raw};
      ce_last <= ce_pipe[STAGES-1];
    end
  end

  assign ce_low  = ~ce_pipe[STAGES-1];
  assign we_low  = ~we_pipe[STAGES-1];
  assign ce_fall = ce_last & ~ce_pipe[STAGES-1];
endmodule

// File: rtl/nvseq_match.sv
module nvseq_match
  import nvseq_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter logic [PREFIX_LEN-1:0][ADDR_W-1:0] PREFIX = '0,
  parameter logic [ADDR_W-1:0] STORE_LAST  = '0,
  parameter logic [ADDR_W-1:0] RECALL_LAST = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              strobe,
  input  logic              abort,
  input  logic [ADDR_W-1:0] addr,
  output logic              store_hit,
  output logic              recall_hit
);
  localparam int STEP_W = $clog2(SEQ_LEN);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(PREFIX_LEN);

  logic [STEP_W-1:0]     step;
  logic [PREFIX_LEN-1:0] hit_vec;
  logic                  next_ok;

  for (genvar i = 0; i < PREFIX_LEN; i++) begin : g_cmp
    assign hit_vec[i] = (addr == PREFIX[i]);
  end

  always_comb begin
    next_ok = 1'b0;
    for (int i = 0; i < PREFIX_LEN; i++)
      if (step == STEP_W'(i)) next_ok = hit_vec[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step       <= '0;
      store_hit  <= 1'b0;
      recall_hit <= 1'b0;
    end else begin
      store_hit  <= 1'b0;
      recall_hit <= 1'b0;
      if (hold || abort) begin
        step <= '0;
      end else if (strobe) begin
        if (step == LAST_STEP) begin
          step <= hit_vec[0] ? STEP_W'(1) : '0;
          if (addr == STORE_LAST) begin
            store_hit <= 1'b1;
            step      <= '0;
          end else if (addr == RECALL_LAST) begin
            recall_hit <= 1'b1;
            step       <= '0;
          end
        end else if (next_ok) begin
          step <= step + STEP_W'(1);
        end else begin
          step <= hit_vec[0] ? STEP_W'(1) : '0;
        end
      end
    end
  end
endmodule

// File: rtl/nvseq_timer.sv
module nvseq_timer
  import nvseq_pkg::*;
#(
  parameter int STORE_CYCLES  = 500,
  parameter int ERASE_CYCLES  = 200,
  parameter int RECALL_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic start_store,
  input  logic start_recall,
  output logic busy,
  output logic erase_active,
  output logic program_active
);
  localparam int MAX_CYC = (STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] PROG_LEFT = CNT_W'(STORE_CYCLES - ERASE_CYCLES);

  logic [CNT_W-1:0] remain;
  nv_op_e           op;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      remain <= '0;
      op     <= OP_IDLE;
    end else if (!busy) begin
      if (start_store) begin
        busy   <= 1'b1;
        remain <= CNT_W'(STORE_CYCLES - 1);
        op     <= OP_STORE;
      end else if (start_recall) begin
        busy   <= 1'b1;
        remain <= CNT_W'(RECALL_CYCLES - 1);
        op     <= OP_RECALL;
      end
    end else if (remain == '0) begin
      busy <= 1'b0;
      op   <= OP_IDLE;
    end else begin
      remain <= remain - CNT_W'(1);
    end
  end

  assign erase_active   = busy && (op == OP_STORE) && (remain >= PROG_LEFT);
  assign program_active = busy && (op == OP_STORE) && (remain <  PROG_LEFT);
endmodule

// File: rtl/nvseq_detect.sv
module nvseq_detect
  import nvseq_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int SYNC_STAGES = 2,
  parameter logic [PREFIX_LEN-1:0][ADDR_W-1:0] PREFIX =
    {15'h7B9, 15'h51E, 15'h2F0, 15'h6C3, 15'h1A5},
  parameter logic [ADDR_W-1:0] STORE_LAST  = 15'h0D4,
  parameter logic [ADDR_W-1:0] RECALL_LAST = 15'h3E7,
  parameter int STORE_CYCLES  = 500,
  parameter int ERASE_CYCLES  = 200,
  parameter int RECALL_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              store_req,
  output logic              recall_req,
  output logic              bus_inhibit,
  output logic              erase_active,
  output logic              program_active
);
  logic ce_low, we_low, ce_fall;
  logic wr_abort, hold_seq;

  nvseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .ce_n_raw(ce_n), .we_n_raw(we_n),
    .ce_low(ce_low), .we_low(we_low), .ce_fall(ce_fall)
  );

  assign wr_abort = ce_low & we_low;
  assign hold_seq = bus_inhibit | store_req | recall_req;

  nvseq_match #(
    .ADDR_W(ADDR_W), .PREFIX(PREFIX),
    .STORE_LAST(STORE_LAST), .RECALL_LAST(RECALL_LAST)
  ) u_match (
    .clk(clk), .rst(rst), .hold(hold_seq), .strobe(ce_fall),
    .abort(wr_abort), .addr(addr),
    .store_hit(store_req), .recall_hit(recall_req)
  );

  nvseq_timer #(
    .STORE_CYCLES(STORE_CYCLES), .ERASE_CYCLES(ERASE_CYCLES),
    .RECALL_CYCLES(RECALL_CYCLES)
  ) u_timer (
    .clk(clk), .rst(rst), .start_store(store_req), .start_recall(recall_req),
    .busy(bus_inhibit), .erase_active(erase_active),
    .program_active(program_active)
  );
endmodule

// File: rtl/nvseq_detect_chk.sv
module nvseq_detect_chk (
  input logic clk,
  input logic rst,
  input logic store_req,
  input logic recall_req,
  input logic bus_inhibit,
  input logic erase_active,
  input logic program_active
);
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({store_req, recall_req}));                                  // R3
  AST_STORE_PULSE: assert property (@(posedge clk) disable iff (rst)
    store_req |=> !store_req);                                           // R2
  AST_RECALL_PULSE: assert property (@(posedge clk) disable iff (rst)
    recall_req |=> !recall_req);                                         // R3
  AST_STORE_BUSY: assert property (@(posedge clk) disable iff (rst)
    store_req |=> bus_inhibit && erase_active);                          // R7
  AST_RECALL_NO_PHASE: assert property (@(posedge clk) disable iff (rst)
    recall_req |=> bus_inhibit && !erase_active && !program_active);     // R9
  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(erase_active && program_active));                                  // R8
  AST_ERASE_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(program_active) |-> $past(erase_active));                      // R8
  AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    bus_inhibit |-> !store_req && !recall_req);                          // R10
endmodule

bind nvseq_detect nvseq_detect_chk u_chk (
  .clk(clk), .rst(rst), .store_req(store_req), .recall_req(recall_req),
  .bus_inhibit(bus_inhibit), .erase_active(erase_active),
  .program_active(program_active)
);

// File: tb/nvseq_detect_tb.sv
module nvseq_detect_tb;
  localparam int AW = 15;
  localparam int ST_CYC = 500, ER_CYC = 200, RC_CYC = 1000;
  localparam logic [AW-1:0] A0 = 15'h1A5, A1 = 15'h6C3, A2 = 15'h2F0,
                            A3 = 15'h51E, A4 = 15'h7B9,
                            ASTORE = 15'h0D4, ARECALL = 15'h3E7, AOTHER = 15'h444;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic store_req, recall_req, bus_inhibit, erase_active, program_active;

  int n_tests = 0, n_fail = 0;
  int store_cnt = 0, recall_cnt = 0, long_pulse = 0;
  int busy_run = 0, busy_len = 0, er_run = 0, er_len = 0, pr_run = 0, pr_len = 0;
  int order_bad = 0, late_busy = 0;
  logic prev_st = 0, prev_rc = 0, prev_er = 0, prev_pr = 0, req_prev = 0;
  bit done = 0;

  always #10 clk = ~clk;

  nvseq_detect u_dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .addr(addr),
    .store_req(store_req), .recall_req(recall_req), .bus_inhibit(bus_inhibit),
    .erase_active(erase_active), .program_active(program_active)
  );

  always @(negedge clk) if (!rst) begin
    if (store_req) store_cnt++;
    if (recall_req) recall_cnt++;
    if ((store_req && prev_st) || (recall_req && prev_rc)) long_pulse++;
    if (req_prev && !bus_inhibit) late_busy++;
    if (program_active && !prev_pr && !prev_er) order_bad++;
    if (bus_inhibit) busy_run++; else if (busy_run != 0) begin busy_len = busy_run; busy_run = 0; end
    if (erase_active) er_run++; else if (er_run != 0) begin er_len = er_run; er_run = 0; end
    if (program_active) pr_run++; else if (pr_run != 0) begin pr_len = pr_run; pr_run = 0; end
    prev_st = store_req; prev_rc = recall_req; req_prev = store_req | recall_req;
    prev_er = erase_active; prev_pr = program_active;
  end

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_cycle(input logic [AW-1:0] a, input bit wr, input int low_clks);
    @(negedge clk);
    addr = a; we_n = ~wr; ce_n = 1'b0;
    repeat (low_clks) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a);
    bus_cycle(a, 1'b0, 4);
  endtask

  task automatic prefix();
    rd(A0); rd(A1); rd(A2); rd(A3); rd(A4);
  endtask

  task automatic settle();
    for (int i = 0; i < 3000 && (bus_inhibit || busy_run != 0); i++) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 store_req", store_req, 0);
    check("R1 recall_req", recall_req, 0);
    check("R1 bus_inhibit", bus_inhibit, 0);
    check("R1 phases", erase_active | program_active, 0);
  endtask

  task automatic t_store();
    int s0 = store_cnt, r0 = recall_cnt;
    prefix(); rd(ASTORE); settle();
    check("R2 store pulses", store_cnt - s0, 1);
    check("R2 no recall", recall_cnt - r0, 0);
    check("R2 pulse width", long_pulse, 0);
    check("R7 busy length", busy_len, ST_CYC);
    check("R7 busy follows req", late_busy, 0);
    check("R8 erase length", er_len, ER_CYC);
    check("R8 program length", pr_len, ST_CYC - ER_CYC);
    check("R8 order", order_bad, 0);
  endtask

  task automatic t_recall();
    int s0 = store_cnt, r0 = recall_cnt;
    er_len = 0; pr_len = 0;
    prefix(); rd(ARECALL); settle();
    check("R3 recall pulses", recall_cnt - r0, 1);
    check("R3 no store", store_cnt - s0, 0);
    check("R9 busy length", busy_len, RC_CYC);
    check("R9 no phases", er_len + pr_len, 0);
  endtask

  task automatic t_mismatch();
    int s0 = store_cnt;
    rd(A0); rd(A1); rd(A2); rd(AOTHER); rd(A3); rd(A4); rd(ASTORE); settle();
    check("R4 mismatch clears", store_cnt - s0, 0);
    s0 = store_cnt;
    rd(A0); rd(A1); rd(A2); rd(A3); rd(A0); rd(A1); rd(A2); rd(A3); rd(A4); rd(ASTORE);
    settle();
    check("R4 restart at first entry", store_cnt - s0, 1);
  endtask

  task automatic t_write_abort();
    int s0 = store_cnt;
    rd(A0); rd(A1); rd(A2); bus_cycle(A3, 1'b1, 4); rd(A4); rd(ASTORE); settle();
    check("R5 write aborts", store_cnt - s0, 0);
    s0 = store_cnt;
    rd(A0); rd(A1); rd(A2); bus_cycle(A3, 1'b1, 4); rd(A3); rd(A4); rd(ASTORE); settle();
    check("R5 write aborts before matching addr", store_cnt - s0, 0);
  endtask

  task automatic t_long_low();
    int s0 = store_cnt;
    bus_cycle(A0, 1'b0, 40); bus_cycle(A1, 1'b0, 25); rd(A2); rd(A3);
    bus_cycle(A4, 1'b0, 30); rd(ASTORE); settle();
    check("R6 long low counts once", store_cnt - s0, 1);
    s0 = store_cnt;
    rd(A0); rd(A1); rd(A1); rd(A2); rd(A3); rd(A4); rd(ASTORE); settle();
    check("R6 repeated address is a step", store_cnt - s0, 0);
  endtask

  task automatic t_busy_ignore();
    int s0 = store_cnt, r0 = recall_cnt;
    prefix(); rd(ASTORE);
    repeat (5) @(negedge clk);
    check("R10 busy started", bus_inhibit, 1);
    prefix(); rd(ARECALL);
    check("R10 still busy", bus_inhibit, 1);
    settle();
    check("R10 one store only", store_cnt - s0, 1);
    check("R10 no recall", recall_cnt - r0, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_store();
    t_recall();
    t_mismatch();
    t_write_abort();
    t_long_low();
    t_busy_ignore();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(negedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule